// File: doc/BRIEF.md
# Addressing and Immediate Byte Collector

This block is the back half of an instruction-length decoder for a variable-length instruction encoding. The prefix and opcode stage has already worked out which opcode map the opcode came from, the opcode byte itself, the effective operand and address sizes, whether a ModRM byte follows, and a preliminary immediate length from its tables. A one-cycle `start` pulse hands that context over. The collector then takes the remaining instruction bytes, one per cycle whenever `byte_valid` is high.

The first byte, when present, is the ModRM byte. From it the block decides whether a SIB byte follows, how long the displacement is, and whether a special immediate rule replaces the table length. It then gathers the displacement and immediate bytes, lowest byte first, and sign-extends each one as the encoding requires. When the last field is complete, it pulses `done` for one cycle. Stalls in the byte stream may occur anywhere, and the block simply waits through them.

Top module: `tailcol_top`

## Requirements
- R1: With 16-bit addressing (`addr_size_log`=1) the displacement is 2 bytes when mod=2, or when mod=0 and rm=6. It is 1 byte when mod=1, and 0 bytes otherwise. ModRM fields: mod=bits 7:6, reg=bits 5:3, rm=bits 2:0.
- R2: With 32-bit or 64-bit addressing (`addr_size_log`=2 or 3) the displacement is 4 bytes when mod=2, or when mod=0 and rm=5. It is 1 byte when mod=1, and 0 bytes otherwise.
- R3: A SIB byte follows the ModRM byte only when rm=4, mod is not 3, and addressing is not 16-bit. `sib_out` stays 0 in every other case.
- R4: When mod=0 and the SIB base field (bits 2:0) equals 5, the displacement is 4 bytes. A base of 5 with mod 1 or 2 keeps the length set by R2.
- R5: For the primary opcode map (`op_map`=0) with ModRM reg bits 2:1 equal to 00, opcode F6 takes a 1-byte immediate. Opcode F7 takes an immediate as wide as the operand size (1 << `op_size_log` bytes), limited to 4 bytes. Every other case uses `imm_len_in`.
- R6: Fields are taken in this order: ModRM, SIB, displacement, immediate. Fields of zero length are skipped. `done` is high for exactly the one cycle after the clock edge that accepts the last byte. If there are no fields, it is high in the cycle after the edge that accepts `start`.
- R7: A displacement of 1, 2 or 4 bytes appears on `disp_out` sign-extended to 64 bits, and its length appears on `disp_len_out`.
- R8: An immediate of 1 or 4 bytes is sign-extended to 64 bits. An immediate of 2 or 8 bytes is zero-extended.
- R9: Multi-byte fields are built little-endian, with the first byte in bits 7:0. The byte count restarts for the immediate after the displacement.
- R10: When `byte_valid` is low, nothing advances. Bytes offered while the block is idle are ignored. A `start` pulse while `busy` is high is ignored.
- R11: After reset, all outputs are 0. An accepted `start` clears `modrm_out`, `sib_out`, `disp_out`, `disp_len_out` and `imm_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Loads the instruction context; accepted only while idle |
| op_map | input | 2 | Opcode map: 0 primary, 1 0F escape, 2 0F38 escape, 3 0F3A escape |
| opcode | input | 8 | Final opcode byte |
| op_size_log | input | 2 | log2 of operand size in bytes (1..3) |
| addr_size_log | input | 2 | log2 of address size in bytes (1=16-bit, 2=32-bit, 3=64-bit) |
| has_modrm | input | 1 | A ModRM byte follows |
| imm_len_in | input | 4 | Immediate length from the opcode tables: 0, 1, 2, 4 or 8 |
| byte_valid | input | 1 | `byte_in` carries an instruction byte |
| byte_in | input | 8 | Next instruction byte |
| busy | output | 1 | Collecting fields of the current instruction |
| modrm_out | output | 8 | Captured ModRM byte |
| sib_out | output | 8 | Captured SIB byte |
| disp_out | output | 64 | Sign-extended displacement |
| disp_len_out | output | 4 | Displacement length in bytes |
| imm_out | output | 64 | Extended immediate |
| done | output | 1 | One-cycle pulse: instruction fields complete |

## Verification
The assertions assume that `imm_len_in` is one of 0, 1, 2, 4 or 8. They also assume that `op_size_log` and `addr_size_log` stay in the range 1 to 3, so every field length is a real byte count. The bench only uses encodings inside those ranges. It changes inputs on the falling clock edge, so every byte is stable at the sampling edge. Stalls, stray `start` pulses while busy, and bytes offered while idle all go through the block's normal inputs.

// File: rtl/tailcol_pkg.sv
package tailcol_pkg;

    localparam int BYTE_W = 8;
    localparam int VAL_W  = 64;
    localparam int LEN_W  = 4;
    localparam int NBYTES = VAL_W / BYTE_W;
    localparam int CNT_W  = $clog2(NBYTES);

    typedef enum logic [1:0] {
        MAP_PRIMARY = 2'd0,
        MAP_ESC     = 2'd1,
        MAP_ESC38   = 2'd2,
        MAP_ESC3A   = 2'd3
    } opmap_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MODRM,
        ST_SIB,
        ST_DISP,
        ST_IMM
    } phase_e;

    typedef struct packed {
        logic [1:0] md;
        logic [2:0] reg_f;
        logic [2:0] rm;
    } modrm_t;

    typedef struct packed {
        opmap_e     map;
        logic [7:0] opc;
        logic [1:0] op_log;
        logic       a16;
    } ctx_t;

    // Pick the first field still owed, or idle when none remain.
    function automatic phase_e route(input logic sib,
                                     input logic [LEN_W-1:0] dl,
                                     input logic [LEN_W-1:0] il);
        if (sib)
            return ST_SIB;
        else if (dl != '0)
            return ST_DISP;
        else if (il != '0)
            return ST_IMM;
        else
            return ST_IDLE;
    endfunction

    function automatic logic [VAL_W-1:0] sext_disp(input logic [VAL_W-1:0] v,
                                                   input logic [LEN_W-1:0] len);
        case (len)
            4'd1:    return {{56{v[7]}},  v[7:0]};
            4'd2:    return {{48{v[15]}}, v[15:0]};
            4'd4:    return {{32{v[31]}}, v[31:0]};
            default: return v;
        endcase
    endfunction

    function automatic logic [VAL_W-1:0] sext_imm(input logic [VAL_W-1:0] v,
                                                  input logic [LEN_W-1:0] len);
        case (len)
            4'd1:    return {{56{v[7]}},  v[7:0]};
            4'd2:    return {48'd0, v[15:0]};
            4'd4:    return {{32{v[31]}}, v[31:0]};
            default: return v;
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] log_to_len(input logic [1:0] lg);
        return LEN_W'(1) << lg;
    endfunction

endpackage

// File: rtl/tailcol_modrm_rules.sv
module tailcol_modrm_rules
    import tailcol_pkg::*;
(
    input  modrm_t           mrm,
    input  logic             a16,
    input  opmap_e           map,
    input  logic [7:0]       opc,
    input  logic [1:0]       op_log,
    input  logic [LEN_W-1:0] imm_in,
    output logic             need_sib,
    output logic [LEN_W-1:0] disp_len,
    output logic [LEN_W-1:0] imm_len
);
    logic [LEN_W-1:0] wide_len;
    logic [LEN_W-1:0] op_len;

    always_comb begin
        wide_len = a16 ? LEN_W'(2) : LEN_W'(4);
        if (mrm.md == 2'd2)
            disp_len = wide_len;
        else if (mrm.md == 2'd1)
            disp_len = LEN_W'(1);
        else if (mrm.md == 2'd0 && ((a16 && mrm.rm == 3'd6) || (!a16 && mrm.rm == 3'd5)))
            disp_len = wide_len;
        else
            disp_len = '0;

        need_sib = !a16 && (mrm.rm == 3'd4) && (mrm.md != 2'd3);

        // Group-3 TEST carries an immediate that its siblings lack.
        op_len  = log_to_len(op_log);
        imm_len = imm_in;
        if (map == MAP_PRIMARY && mrm.reg_f[2:1] == 2'b00) begin
            if (opc == 8'hF6)
                imm_len = LEN_W'(1);
            else if (opc == 8'hF7)
                imm_len = (op_len == LEN_W'(8)) ? LEN_W'(4) : op_len;
        end
    end
endmodule

// File: rtl/tailcol_field_acc.sv
module tailcol_field_acc #(
    parameter int VW = 64,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          take,
    input  logic [BW-1:0] byte_in,
    output logic [$clog2(VW/BW)-1:0] cnt,
    output logic [VW-1:0] merged
);
    logic [VW-1:0] acc_q;

    // Current value with the incoming byte dropped into its slot.
    always_comb begin
        merged = acc_q;
        merged[cnt*BW +: BW] = byte_in;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
            cnt   <= '0;
        end else if (take) begin
            acc_q <= merged;
            cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tailcol_top.sv
module tailcol_top
    import tailcol_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [1:0]  op_map,
    input  logic [7:0]  opcode,
    input  logic [1:0]  op_size_log,
    input  logic [1:0]  addr_size_log,
    input  logic        has_modrm,
    input  logic [3:0]  imm_len_in,
    input  logic        byte_valid,
    input  logic [7:0]  byte_in,
    output logic        busy,
    output logic [7:0]  modrm_out,
    output logic [7:0]  sib_out,
    output logic [63:0] disp_out,
    output logic [3:0]  disp_len_out,
    output logic [63:0] imm_out,
    output logic        done
);
    phase_e           state_q, nxt;
    ctx_t             ctx_q;
    logic [LEN_W-1:0] dlen_q, ilen_q;
    logic             mod0_q;
    logic             fin;
    logic             take, start_ok;
    logic             last_d, last_i;
    logic             acc_take, acc_clear;
    logic [LEN_W-1:0] sib_dlen;
    logic [CNT_W-1:0] cnt;
    logic [VAL_W-1:0] merged;
    logic             r_sib;
    logic [LEN_W-1:0] r_dlen, r_ilen;

    tailcol_modrm_rules u_rules (
        .mrm      (modrm_t'(byte_in)),
        .a16      (ctx_q.a16),
        .map      (ctx_q.map),
        .opc      (ctx_q.opc),
        .op_log   (ctx_q.op_log),
        .imm_in   (ilen_q),
        .need_sib (r_sib),
        .disp_len (r_dlen),
        .imm_len  (r_ilen)
    );

    tailcol_field_acc #(.VW(VAL_W), .BW(BYTE_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clear   (acc_clear),
        .take    (acc_take),
        .byte_in (byte_in),
        .cnt     (cnt),
        .merged  (merged)
    );

    always_comb begin
        busy     = (state_q != ST_IDLE);
        take     = byte_valid && busy;
        start_ok = start && !busy;
        last_d   = (LEN_W'(cnt) + LEN_W'(1)) == dlen_q;
        last_i   = (LEN_W'(cnt) + LEN_W'(1)) == ilen_q;
        sib_dlen = (mod0_q && byte_in[2:0] == 3'd5) ? LEN_W'(4) : dlen_q;
        acc_take  = take && (state_q == ST_DISP || state_q == ST_IMM);
        acc_clear = start_ok
                  || (take && state_q == ST_DISP && last_d)
                  || (take && state_q == ST_IMM  && last_i);

        nxt = state_q;
        fin = 1'b0;
        case (state_q)
            ST_IDLE: if (start_ok) begin
                nxt = has_modrm ? ST_MODRM : route(1'b0, '0, imm_len_in);
                fin = (nxt == ST_IDLE);
            end
            ST_MODRM: if (take) begin
                nxt = route(r_sib, r_dlen, r_ilen);
                fin = (nxt == ST_IDLE);
            end
            ST_SIB: if (take) begin
                nxt = route(1'b0, sib_dlen, ilen_q);
                fin = (nxt == ST_IDLE);
            end
            ST_DISP: if (take && last_d) begin
                nxt = route(1'b0, '0, ilen_q);
                fin = (nxt == ST_IDLE);
            end
            ST_IMM: if (take && last_i) begin
                nxt = ST_IDLE;
                fin = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            ctx_q        <= '0;
            dlen_q       <= '0;
            ilen_q       <= '0;
            mod0_q       <= 1'b0;
            modrm_out    <= '0;
            sib_out      <= '0;
            disp_out     <= '0;
            disp_len_out <= '0;
            imm_out      <= '0;
            done         <= 1'b0;
        end else begin
            state_q <= nxt;
            done    <= fin;
            case (state_q)
                ST_IDLE: if (start_ok) begin
                    ctx_q.map    <= opmap_e'(op_map);
                    ctx_q.opc    <= opcode;
                    ctx_q.op_log <= op_size_log;
                    ctx_q.a16    <= (addr_size_log == 2'd1);
                    ilen_q       <= imm_len_in;
                    dlen_q       <= '0;
                    mod0_q       <= 1'b0;
                    modrm_out    <= '0;
                    sib_out      <= '0;
                    disp_out     <= '0;
                    disp_len_out <= '0;
                    imm_out      <= '0;
                end
                ST_MODRM: if (take) begin
                    modrm_out <= byte_in;
                    dlen_q    <= r_dlen;
                    ilen_q    <= r_ilen;
                    mod0_q    <= (byte_in[7:6] == 2'd0);
                end
                ST_SIB: if (take) begin
                    sib_out <= byte_in;
                    dlen_q  <= sib_dlen;
                end
                ST_DISP: if (take && last_d) begin
                    disp_out     <= sext_disp(merged, dlen_q);
                    disp_len_out <= dlen_q;
                end
                ST_IMM: if (take && last_i) begin
                    imm_out <= sext_imm(merged, ilen_q);
                end
                default: ;
            endcase
        end
    end

    // R10: a stalled stream freezes progress and results
    a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (busy && !byte_valid) |=> ($stable(state_q) && $stable(disp_out) && $stable(imm_out)));

    // R3: 16-bit addressing never visits the SIB stage
    a_r3_no_sib_16: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MODRM && ctx_q.a16) |=> (state_q != ST_SIB));

    // R1: 16-bit addressing never produces a 4-byte displacement
    a_r1_len16: assert property (@(posedge clk) disable iff (rst)
        (ctx_q.a16 && state_q == ST_DISP) |-> (dlen_q != LEN_W'(4)));

    // R4: mod 0 with SIB base 5 always moves on to a displacement
    a_r4_base5_disp: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SIB && byte_valid && mod0_q && byte_in[2:0] == 3'd5) |=> (state_q == ST_DISP));

    // R9: byte count stays below the field length while gathering
    a_r9_cnt_disp: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DISP) |-> (LEN_W'(cnt) < dlen_q));
    a_r9_cnt_imm: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IMM) |-> (LEN_W'(cnt) < ilen_q));

    // R6: completion is only reported once collection has stopped
    a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (state_q == ST_IDLE));

endmodule

// File: tb/tailcol_top_test.sv
module tailcol_top_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [1:0]  op_map;
    logic [7:0]  opcode;
    logic [1:0]  op_size_log;
    logic [1:0]  addr_size_log;
    logic        has_modrm;
    logic [3:0]  imm_len_in;
    logic        byte_valid;
    logic [7:0]  byte_in;
    logic        busy;
    logic [7:0]  modrm_out;
    logic [7:0]  sib_out;
    logic [63:0] disp_out;
    logic [3:0]  disp_len_out;
    logic [63:0] imm_out;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;
    logic [7:0] seq [16];
    int seq_n = 0;

    tailcol_top uut (
        .clk(clk), .rst(rst), .start(start), .op_map(op_map), .opcode(opcode),
        .op_size_log(op_size_log), .addr_size_log(addr_size_log),
        .has_modrm(has_modrm), .imm_len_in(imm_len_in),
        .byte_valid(byte_valid), .byte_in(byte_in), .busy(busy),
        .modrm_out(modrm_out), .sib_out(sib_out), .disp_out(disp_out),
        .disp_len_out(disp_len_out), .imm_out(imm_out), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic clear_seq();
        seq_n = 0;
    endtask

    task automatic push(input logic [7:0] b);
        seq[seq_n] = b;
        seq_n++;
    endtask

    // Drive one instruction tail and check the completed fields.
    task automatic run_case(input string rq, input logic [1:0] mp, input logic [7:0] opc,
                            input logic [1:0] olog, input logic [1:0] alog,
                            input logic hm, input logic [3:0] il, input bit stall,
                            input logic [7:0] e_modrm, input logic [7:0] e_sib,
                            input logic [63:0] e_disp, input logic [3:0] e_dl,
                            input logic [63:0] e_imm);
        @(negedge clk);
        start = 1'b1; op_map = mp; opcode = opc; op_size_log = olog;
        addr_size_log = alog; has_modrm = hm; imm_len_in = il;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < seq_n; i++) begin
            byte_valid = 1'b1;
            byte_in = seq[i];
            @(negedge clk);
            if (i < seq_n - 1) begin
                chk(rq, "done early", {63'd0, done}, 64'd0);
                if (stall) begin
                    // R10: stall cycle with a stray start and altered context
                    byte_valid = 1'b0; byte_in = 8'hAA;
                    start = 1'b1; has_modrm = 1'b0; imm_len_in = 4'd0; addr_size_log = 2'd3;
                    @(negedge clk);
                    start = 1'b0; has_modrm = hm; imm_len_in = il; addr_size_log = alog;
                    chk("R10", "busy in stall", {63'd0, busy}, 64'd1);
                    chk("R10", "done in stall", {63'd0, done}, 64'd0);
                end
            end
        end
        byte_valid = 1'b0;
        chk(rq, "done", {63'd0, done}, 64'd1);
        chk(rq, "modrm", {56'd0, modrm_out}, {56'd0, e_modrm});
        chk(rq, "sib", {56'd0, sib_out}, {56'd0, e_sib});
        chk(rq, "disp", disp_out, e_disp);
        chk(rq, "disp_len", {60'd0, disp_len_out}, {60'd0, e_dl});
        chk(rq, "imm", imm_out, e_imm);
        @(negedge clk);
        chk("R6", "done width", {63'd0, done}, 64'd0);
        chk("R6", "idle after", {63'd0, busy}, 64'd0);
    endtask

    task automatic t_reset();
        chk("R11", "reset done", {63'd0, done}, 64'd0);
        chk("R11", "reset busy", {63'd0, busy}, 64'd0);
        chk("R11", "reset disp", disp_out, 64'd0);
        chk("R11", "reset imm", imm_out, 64'd0);
    endtask

    task automatic t_idle_bytes();
        // R10: bytes while idle are ignored
        for (int i = 0; i < 3; i++) begin
            byte_valid = 1'b1; byte_in = 8'h44;
            @(negedge clk);
            chk("R10", "idle busy", {63'd0, busy}, 64'd0);
            chk("R10", "idle done", {63'd0, done}, 64'd0);
        end
        byte_valid = 1'b0;
    endtask

    task automatic t_r1_16bit();
        clear_seq(); push(8'h06); push(8'h34); push(8'h92);
        run_case("R1", 2'd0, 8'h8B, 2'd1, 2'd1, 1'b1, 4'd0, 1'b0,
                 8'h06, 8'h00, 64'hFFFF_FFFF_FFFF_9234, 4'd2, 64'd0);
        clear_seq(); push(8'h44); push(8'h80);
        run_case("R3", 2'd0, 8'h8B, 2'd1, 2'd1, 1'b1, 4'd0, 1'b0,
                 8'h44, 8'h00, 64'hFFFF_FFFF_FFFF_FF80, 4'd1, 64'd0);
        clear_seq(); push(8'h87); push(8'h10); push(8'h00);
        run_case("R1", 2'd0, 8'h8B, 2'd1, 2'd1, 1'b1, 4'd0, 1'b0,
                 8'h87, 8'h00, 64'h0000_0000_0000_0010, 4'd2, 64'd0);
    endtask

    task automatic t_r2_32bit();
        clear_seq(); push(8'h05); push(8'h78); push(8'h56); push(8'h34); push(8'h12);
        run_case("R2", 2'd0, 8'h8B, 2'd2, 2'd2, 1'b1, 4'd0, 1'b0,
                 8'h05, 8'h00, 64'h0000_0000_1234_5678, 4'd4, 64'd0);
        clear_seq(); push(8'h84); push(8'h24); push(8'h00); push(8'h00);
        push(8'h00); push(8'h80); push(8'h7F);
        run_case("R7", 2'd0, 8'h83, 2'd3, 2'd3, 1'b1, 4'd1, 1'b1,
                 8'h84, 8'h24, 64'hFFFF_FFFF_8000_0000, 4'd4, 64'h7F);
    endtask

    task automatic t_r4_sib();
        clear_seq(); push(8'h04); push(8'h25); push(8'h01); push(8'h00); push(8'h00); push(8'h00);
        run_case("R4", 2'd0, 8'h8B, 2'd3, 2'd3, 1'b1, 4'd0, 1'b0,
                 8'h04, 8'h25, 64'd1, 4'd4, 64'd0);
        clear_seq(); push(8'h04); push(8'h0C);
        run_case("R3", 2'd0, 8'h8B, 2'd2, 2'd2, 1'b1, 4'd0, 1'b0,
                 8'h04, 8'h0C, 64'd0, 4'd0, 64'd0);
        clear_seq(); push(8'h44); push(8'h25); push(8'hF0);
        run_case("R4", 2'd0, 8'h8B, 2'd2, 2'd2, 1'b1, 4'd0, 1'b0,
                 8'h44, 8'h25, 64'hFFFF_FFFF_FFFF_FFF0, 4'd1, 64'd0);
        clear_seq(); push(8'hC4); push(8'hF0); push(8'hFF); push(8'hFF); push(8'hFF);
        run_case("R8", 2'd0, 8'h81, 2'd2, 2'd2, 1'b1, 4'd4, 1'b0,
                 8'hC4, 8'h00, 64'd0, 4'd0, 64'hFFFF_FFFF_FFFF_FFF0);
    endtask

    task automatic t_r5_test_imm();
        clear_seq(); push(8'hC0); push(8'h85);
        run_case("R5", 2'd0, 8'hF6, 2'd2, 2'd2, 1'b1, 4'd0, 1'b0,
                 8'hC0, 8'h00, 64'd0, 4'd0, 64'hFFFF_FFFF_FFFF_FF85);
        clear_seq(); push(8'hC8); push(8'h00); push(8'h00); push(8'h00); push(8'h80);
        run_case("R5", 2'd0, 8'hF7, 2'd3, 2'd3, 1'b1, 4'd0, 1'b0,
                 8'hC8, 8'h00, 64'd0, 4'd0, 64'hFFFF_FFFF_8000_0000);
        clear_seq(); push(8'hC0); push(8'hFF); push(8'hFF);
        run_case("R5", 2'd0, 8'hF7, 2'd1, 2'd2, 1'b1, 4'd0, 1'b0,
                 8'hC0, 8'h00, 64'd0, 4'd0, 64'h0000_0000_0000_FFFF);
        clear_seq(); push(8'hD0);
        run_case("R5", 2'd0, 8'hF7, 2'd2, 2'd2, 1'b1, 4'd0, 1'b0,
                 8'hD0, 8'h00, 64'd0, 4'd0, 64'd0);
        clear_seq(); push(8'hC0);
        run_case("R5", 2'd1, 8'hF7, 2'd2, 2'd2, 1'b1, 4'd0, 1'b0,
                 8'hC0, 8'h00, 64'd0, 4'd0, 64'd0);
        // R9: disp then immediate, count restarts for the immediate
        clear_seq(); push(8'h46); push(8'hFE); push(8'h34); push(8'h12);
        run_case("R9", 2'd0, 8'hF7, 2'd1, 2'd1, 1'b1, 4'd0, 1'b1,
                 8'h46, 8'h00, 64'hFFFF_FFFF_FFFF_FFFE, 4'd1, 64'h0000_0000_0000_1234);
    endtask

    task automatic t_no_modrm();
        clear_seq();
        for (int i = 1; i < 8; i++) push(8'(i));
        push(8'h88);
        run_case("R8", 2'd0, 8'hB8, 2'd3, 2'd3, 1'b0, 4'd8, 1'b1,
                 8'h00, 8'h00, 64'd0, 4'd0, 64'h8807_0605_0403_0201);
        clear_seq();
        run_case("R11", 2'd0, 8'h90, 2'd2, 2'd2, 1'b0, 4'd0, 1'b0,
                 8'h00, 8'h00, 64'd0, 4'd0, 64'd0);
        clear_seq(); push(8'h80); push(8'h00);
        run_case("R8", 2'd0, 8'hC2, 2'd2, 2'd2, 1'b0, 4'd2, 1'b0,
                 8'h00, 8'h00, 64'd0, 4'd0, 64'h0000_0000_0000_0080);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=hung exp=finished");
        summary();
    end

    initial begin
        rst = 1'b1; start = 1'b0; op_map = '0; opcode = '0; op_size_log = 2'd2;
        addr_size_log = 2'd2; has_modrm = 1'b0; imm_len_in = '0;
        byte_valid = 1'b0; byte_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle_bytes();
        t_r1_16bit();
        t_r2_32bit();
        t_r4_sib();
        t_r5_test_imm();
        t_no_modrm();
        repeat (2) @(negedge clk);
        summary();
    end
endmodule